// File: doc/BRIEF.md
# Tearing-Effect Frame Write Gate

This block decides when a display link may begin writing a new frame into the panel's frame memory. The panel drives a tearing-effect (TE) line that shows when its scan-out is clear of the region about to be written. The block watches that line, which is asynchronous to the system clock. When the host raises a frame request, the block waits for the TE line to become active. It then optionally waits a further time delay or a number of line strobes. After that it sends a single-cycle go pulse to the serializer that performs the write.

Three sync modes are supported. In bypass mode the request is passed straight through. In vertical mode the block waits for the TE edge plus a delay given in microseconds. In vertical-plus-line mode it waits for the TE edge plus a count of line strobes. A polarity setting selects whether TE is active high or active low. A busy flag tells the host that a request has been taken and its go pulse has not yet been sent. If the panel never produces TE activity, a pending request stays pending for good.

Top module: `te_write_gate`

## Requirements
- R1: While reset is held and on the first cycle after it, frame_go and busy are both 0.
- R2: With cfg_mode at 0 (bypass) or 3 (reserved, treated as bypass), a request taken while idle yields frame_go high in the cycle right after the one in which frame_req was sampled.
- R3: busy rises in the cycle after an accepted request and stays high through the cycle in which frame_go is high. It is low in the cycle after that.
- R4: Each accepted request produces exactly one single-cycle frame_go. Requests that arrive while busy is high are ignored. TE activity with no request pending produces no frame_go.
- R5: TE passes through a two-flop synchroniser. cfg_pol=1 makes a high level active, and cfg_pol=0 makes a low level active. In vertical mode with a zero delay, frame_go is high in the third cycle after TE changes from inactive to active.
- R6: Only a change of TE from inactive to active after the request is taken starts the wait. If TE is already active when the request arrives, the block waits for TE to go inactive and then active again.
- R7: In vertical mode (cfg_mode=1), frame_go comes cfg_delay_us × (CLK_HZ/1,000,000) cycles later than it would with a zero delay.
- R8: In vertical-plus-line mode (cfg_mode=2), frame_go is high in the cycle after the cfg_line_cnt-th line_pulse that is sampled after the TE edge is recognised. Strobes before that point are not counted. A count of 0 behaves like a zero delay.
- R9: In a sync mode with no TE edge, busy stays high and frame_go stays low for as long as no edge arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | 0 bypass, 1 vertical, 2 vertical plus line strobes, 3 bypass |
| cfg_pol | input | 1 | TE active level (1 = active high) |
| cfg_delay_us | input | DLY_W | Wait after the TE edge, in microseconds (vertical mode) |
| cfg_line_cnt | input | CNT_W | Number of line strobes to wait after the TE edge (line mode) |
| te_in | input | 1 | Asynchronous tearing-effect line from the panel |
| line_pulse | input | 1 | Single-cycle line strobe, synchronous to clk |
| frame_req | input | 1 | Host request to start a frame write |
| frame_go | output | 1 | Single-cycle start pulse to the serializer |
| busy | output | 1 | A request is pending and its go pulse has not yet been sent |

## Verification
On every cycle, the assertions check the handshake between frame_req, busy and frame_go. They confirm that busy rises only after a request, that it holds until the go pulse and drops right after it, and that the go pulse lasts a single cycle. They also confirm that bypass answers in one cycle and that sync modes never answer in that same cycle. Some behaviours can only be shown by the bench's scenarios, because they depend on what happens on TE and line_pulse. These are the exact latency through the synchroniser for both polarities, the microsecond and line-strobe waits, and the need for a fresh TE edge after a request. The bench also shows that strobes arriving before the edge are not counted and that a request with no TE activity waits indefinitely.

// File: rtl/te_gate_pkg.sv
package te_gate_pkg;

  typedef enum logic [1:0] {
    SYNC_OFF       = 2'd0,
    SYNC_VERT      = 2'd1,
    SYNC_VERT_LINE = 2'd2,
    SYNC_RSVD      = 2'd3
  } sync_mode_t;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_ARM     = 3'd1,
    ST_WAIT_US = 3'd2,
    ST_WAIT_LN = 3'd3,
    ST_GO      = 3'd4
  } gate_st_t;

  function automatic logic is_sync_mode(input sync_mode_t m);
    return (m == SYNC_VERT) || (m == SYNC_VERT_LINE);
  endfunction

endpackage

// File: rtl/te_edge_sync.sv
// Brings the asynchronous TE line into the clock domain and flags the
// inactive-to-active transition of the selected polarity.
module te_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic te_in,
  input  logic pol,
  output logic te_rise
);
  logic [STAGES-1:0] sh;
  logic              act_now;
  logic              act_q;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-2:0], te_in};
  end

  assign act_now = pol ? sh[STAGES-1] : ~sh[STAGES-1];

  // Reset to "active" so that no edge is seen until TE has been idle once.
  always_ff @(posedge clk) begin
    if (rst) act_q <= 1'b1;
    else     act_q <= act_now;
  end

  assign te_rise = act_now & ~act_q;

endmodule

// File: rtl/us_prescaler.sv
// Divides the system clock down to one tick per microsecond while enabled.
module us_prescaler #(
  parameter int CLK_HZ = 10_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic tick
);
  localparam int CYC   = (CLK_HZ / 1_000_000 < 1) ? 1 : CLK_HZ / 1_000_000;
  localparam int PRE_W = (CYC > 1) ? $clog2(CYC) : 1;

  logic [PRE_W-1:0] pre;

  assign tick = en && (pre == PRE_W'(CYC - 1));

  always_ff @(posedge clk) begin
    if (rst || clr)  pre <= '0;
    else if (tick)   pre <= '0;
    else if (en)     pre <= pre + PRE_W'(1);
  end

endmodule

// File: rtl/evt_counter.sv
// Counts ticks while enabled and flags the tick that reaches the limit.
module evt_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         en,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         done
);
  logic [W-1:0] cnt;

  assign done = en && tick && (cnt == limit - W'(1));

  always_ff @(posedge clk) begin
    if (rst || start)    cnt <= '0;
    else if (en && tick) cnt <= cnt + W'(1);
  end

endmodule

// File: rtl/te_write_gate.sv
module te_write_gate
  import te_gate_pkg::*;
#(
  parameter int CLK_HZ      = 10_000_000,
  parameter int DLY_W       = 12,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       cfg_mode,
  input  logic             cfg_pol,
  input  logic [DLY_W-1:0] cfg_delay_us,
  input  logic [CNT_W-1:0] cfg_line_cnt,
  input  logic             te_in,
  input  logic             line_pulse,
  input  logic             frame_req,
  output logic             frame_go,
  output logic             busy
);
  sync_mode_t mode;
  gate_st_t   st, st_n;
  logic       te_rise;
  logic       us_tick;
  logic       us_done;
  logic       ln_done;
  logic       arm_hit;
  logic       in_us;
  logic       in_ln;

  assign mode    = sync_mode_t'(cfg_mode);
  assign arm_hit = (st == ST_ARM) && te_rise;
  assign in_us   = (st == ST_WAIT_US);
  assign in_ln   = (st == ST_WAIT_LN);

  te_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .te_in(te_in), .pol(cfg_pol), .te_rise(te_rise)
  );

  us_prescaler #(.CLK_HZ(CLK_HZ)) u_pre (
    .clk(clk), .rst(rst), .clr(arm_hit), .en(in_us), .tick(us_tick)
  );

  evt_counter #(.W(DLY_W)) u_us_cnt (
    .clk(clk), .rst(rst), .start(arm_hit), .en(in_us), .tick(us_tick),
    .limit(cfg_delay_us), .done(us_done)
  );

  evt_counter #(.W(CNT_W)) u_ln_cnt (
    .clk(clk), .rst(rst), .start(arm_hit), .en(in_ln), .tick(line_pulse),
    .limit(cfg_line_cnt), .done(ln_done)
  );

  always_comb begin
    st_n = st;
    unique case (st)
      ST_IDLE: begin
        if (frame_req) st_n = is_sync_mode(mode) ? ST_ARM : ST_GO;
      end
      ST_ARM: begin
        if (!is_sync_mode(mode)) begin
          st_n = ST_GO;
        end else if (te_rise) begin
          if (mode == SYNC_VERT)
            st_n = (cfg_delay_us == '0) ? ST_GO : ST_WAIT_US;
          else
            st_n = (cfg_line_cnt == '0) ? ST_GO : ST_WAIT_LN;
        end
      end
      ST_WAIT_US: if (us_done) st_n = ST_GO;
      ST_WAIT_LN: if (ln_done) st_n = ST_GO;
      ST_GO:      st_n = ST_IDLE;
      default:    st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      frame_go <= 1'b0;
      busy     <= 1'b0;
    end else begin
      st       <= st_n;
      frame_go <= (st_n == ST_GO);
      busy     <= (st_n != ST_IDLE);
    end
  end

endmodule

// File: rtl/te_write_gate_chk.sv
module te_write_gate_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] cfg_mode,
  input logic       frame_req,
  input logic       frame_go,
  input logic       busy
);

  a_r2_bypass_next: assert property (@(posedge clk) disable iff (rst)
    (!busy && frame_req && (cfg_mode == 2'd0 || cfg_mode == 2'd3)) |=> frame_go);

  a_r3_busy_holds: assert property (@(posedge clk) disable iff (rst)
    (busy && !frame_go) |=> busy);

  a_r3_busy_drops: assert property (@(posedge clk) disable iff (rst)
    frame_go |=> !busy);

  a_r3_go_in_busy: assert property (@(posedge clk) disable iff (rst)
    frame_go |-> busy);

  a_r4_single_go: assert property (@(posedge clk) disable iff (rst)
    frame_go |=> !frame_go);

  a_r4_busy_from_req: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(frame_req));

  a_r5_sync_arms: assert property (@(posedge clk) disable iff (rst)
    (!busy && frame_req && (cfg_mode == 2'd1 || cfg_mode == 2'd2)) |=> (busy && !frame_go));

endmodule

bind te_write_gate te_write_gate_chk u_chk (
  .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .frame_req(frame_req),
  .frame_go(frame_go), .busy(busy)
);

// File: tb/te_write_gate_bench.sv
module te_write_gate_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 10_000_000;
  localparam int CYC_US     = CLK_HZ / 1_000_000;
  localparam int DLY_W      = 12;
  localparam int CNT_W      = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [1:0]       cfg_mode = 2'd0;
  logic             cfg_pol = 1'b1;
  logic [DLY_W-1:0] cfg_delay_us = '0;
  logic [CNT_W-1:0] cfg_line_cnt = '0;
  logic             te_in = 1'b0;
  logic             line_pulse = 1'b0;
  logic             frame_req = 1'b0;
  logic             frame_go;
  logic             busy;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  te_write_gate #(.CLK_HZ(CLK_HZ), .DLY_W(DLY_W), .CNT_W(CNT_W)) u_te_write_gate (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_pol(cfg_pol),
    .cfg_delay_us(cfg_delay_us), .cfg_line_cnt(cfg_line_cnt), .te_in(te_in),
    .line_pulse(line_pulse), .frame_req(frame_req), .frame_go(frame_go), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_req();
    @(negedge clk) frame_req = 1'b1;
    @(negedge clk) frame_req = 1'b0;
  endtask

  task automatic te_idle();
    te_in = ~cfg_pol;
    repeat (4) @(negedge clk);
  endtask

  task automatic te_fire(output int lat, input int lim);
    te_in = cfg_pol;
    lat = 0;
    while (!frame_go && lat < lim) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic count_go(input int n, output int gos);
    gos = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (frame_go) gos++;
    end
  endtask

  task automatic t_reset();
    chk(frame_go == 0, "R1 go in reset", frame_go, 0);
    chk(busy == 0, "R1 busy in reset", busy, 0);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    chk(frame_go == 0 && busy == 0, "R1 after reset", {frame_go, busy}, 0);
  endtask

  task automatic t_bypass(input logic [1:0] m);
    cfg_mode = m;
    @(negedge clk) frame_req = 1'b1;
    @(negedge clk) frame_req = 1'b0;
    chk(frame_go == 1, "R2 bypass go", frame_go, 1);
    chk(busy == 1, "R3 busy with go", busy, 1);
    @(negedge clk);
    chk(frame_go == 0 && busy == 0, "R3 released after go", {frame_go, busy}, 0);
  endtask

  task automatic t_single();
    int lat, gos;
    cfg_mode = 2'd1; cfg_pol = 1'b1; cfg_delay_us = '0;
    te_idle();
    do_req();
    chk(busy == 1 && frame_go == 0, "R3 busy after request", {busy, frame_go}, 2);
    do_req();
    te_fire(lat, 50);
    chk(lat == 3, "R5 latency active high", lat, 3);
    @(negedge clk);
    chk(busy == 0, "R3 busy low after go", busy, 0);
    te_in = ~cfg_pol;
    count_go(20, gos);
    te_in = cfg_pol;
    count_go(20, gos);
    chk(gos == 0, "R4 no extra go", gos, 0);
    chk(busy == 0, "R4 extra request ignored", busy, 0);
  endtask

  task automatic t_low_pol();
    int lat;
    cfg_mode = 2'd1; cfg_pol = 1'b0; cfg_delay_us = '0;
    te_idle();
    do_req();
    te_fire(lat, 50);
    chk(lat == 3, "R5 latency active low", lat, 3);
    @(negedge clk);
  endtask

  task automatic t_fresh_edge();
    int lat, gos;
    cfg_mode = 2'd1; cfg_pol = 1'b1; cfg_delay_us = '0;
    te_in = 1'b1;
    repeat (5) @(negedge clk);
    do_req();
    count_go(20, gos);
    chk(gos == 0 && busy == 1, "R6 active level alone ignored", gos, 0);
    te_idle();
    chk(busy == 1, "R6 still pending", busy, 1);
    te_fire(lat, 50);
    chk(lat == 3, "R6 fresh edge latency", lat, 3);
    @(negedge clk);
  endtask

  task automatic t_delay(input int d);
    int lat;
    cfg_mode = 2'd1; cfg_pol = 1'b1; cfg_delay_us = DLY_W'(d);
    te_idle();
    do_req();
    te_fire(lat, 500);
    chk(lat == 3 + d * CYC_US, "R7 microsecond delay", lat, 3 + d * CYC_US);
    @(negedge clk);
  endtask

  task automatic t_lines(input int n);
    int lat;
    cfg_mode = 2'd2; cfg_pol = 1'b1; cfg_line_cnt = CNT_W'(n);
    te_idle();
    do_req();
    if (n == 0) begin
      te_fire(lat, 50);
      chk(lat == 3, "R8 zero line count", lat, 3);
    end else begin
      te_in = 1'b1;
      line_pulse = 1'b1;
      @(negedge clk) line_pulse = 1'b0;
      @(negedge clk);
      @(negedge clk);
      for (int i = 0; i < n; i++) begin
        line_pulse = 1'b1;
        @(negedge clk) line_pulse = 1'b0;
        chk(frame_go == (i == n - 1), "R8 go on last strobe", frame_go, (i == n - 1));
        @(negedge clk);
      end
    end
    @(negedge clk);
  endtask

  task automatic t_no_te();
    int lat, gos;
    cfg_mode = 2'd1; cfg_pol = 1'b1; cfg_delay_us = '0;
    te_idle();
    do_req();
    count_go(500, gos);
    chk(gos == 0, "R9 no go without TE", gos, 0);
    chk(busy == 1, "R9 busy held", busy, 1);
    te_fire(lat, 50);
    chk(lat == 3, "R9 released by TE", lat, 3);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_bypass(2'd0);
    t_bypass(2'd3);
    t_single();
    t_low_pol();
    t_fresh_edge();
    t_delay(1);
    t_delay(2);
    t_lines(3);
    t_lines(0);
    t_no_te();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule